// File: doc/BRIEF.md
# Host Register Bus Slave

This block lets a local microprocessor read and write a bank of byte-wide internal registers over a simple parallel bus. The bus has an 8-bit address, a shared bidirectional 8-bit data path, an active-low select, separate active-low read and write strobes, and an active-low ready output. A read turns on the block's data drivers and presents the contents of the addressed location. A write stores the bus value into the addressed location. In both cases ready falls only once the data is valid or has been stored, and ready rises again shortly after the host releases the strobe.

The strobes reach an internal clock domain in one of two ways, chosen by a mode pin. In free-running mode each strobe passes through a multi-flop synchronizer. In bus-clocked mode the strobes are sampled only at rising edges of a separate bus clock supplied by the host. The bus clock is itself resynchronized into the internal domain. Each select assertion carries exactly one command. The host must raise select before the block will accept another strobe.

Top module: `mpu_reg_slave`

## Requirements
- R1: While reset is asserted, rdy_n is high. After reset, every register location reads back as 0x00.
- R2: While cs_n is high, the strobes have no effect: rdy_n stays high and no location changes.
- R3: With cs_n low, a low rd_n makes rdy_n fall. While rdy_n is low, the block drives data with the contents of the location selected by addr.
- R4: With cs_n low, a low wr_n stores the data value into the location selected by addr. The location already holds the new value when rdy_n falls.
- R5: In free-running mode (sync_mode = 0), each strobe passes through two flops. For a read, rdy_n falls at the third rising clk edge after rd_n falls. For a write, rdy_n falls at the fourth rising clk edge after wr_n falls. In both cases cs_n has already been low for several cycles.
- R6: In free-running mode, rdy_n returns high, and the data drivers turn off, at the third rising clk edge after the active strobe rises.
- R7: Once one command has completed, any further strobe is ignored until cs_n goes high. An ignored strobe causes no ready pulse and no write.
- R8: If rd_n and wr_n are both low when a command would start, the cycle is invalid: no location changes and rdy_n stays high.
- R9: With sync_mode = 1, the strobes are sampled only at rising edges of bus_clk, after bus_clk has been resynchronized into clk. Reads and writes otherwise behave as in R3 and R4.
- R10: All 256 locations are independent. A write to one address changes no other location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 selects bus-clocked strobe sampling |
| bus_clk | input | 1 | Host bus clock, used when sync_mode is 1 |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Register address |
| data | inout | 8 | Bidirectional data bus |
| rdy_n | output | 1 | Active-low command complete |

## Verification
A read strobe and a write strobe can reach the command decoder in the same sampled cycle. The bench provokes this by pulling both low on one clock edge at an address with a known value. It then judges the outcome at the ports: rdy_n must stay high for the whole window, and a later clean read must return the old value. The second collision is between a fresh strobe and a command that has already finished inside the same select window. The bench issues a second write while cs_n is still held low and requires that neither a ready pulse nor a changed location appears.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;
   localparam int B_CS = 2;
   localparam int B_RD = 1;
   localparam int B_WR = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_WHOLD,
      ST_SPENT
   } bus_state_e;
endpackage

// File: rtl/mpu_strobe_sampler.sv
module mpu_strobe_sampler
   import mpu_bus_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_mode,
   input  logic       bus_clk,
   input  logic [2:0] raw_n,
   output logic [2:0] act
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0] chain [SYNC_STAGES];

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '1;
            else        chain[i] <= raw_n;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '1;
            else        chain[i] <= chain[i-1];
      end
   end

   logic [2:0] bclk_q;
   logic       bclk_rise;
   logic [2:0] sync_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bclk_q <= '0;
      else        bclk_q <= {bclk_q[1:0], bus_clk};

   assign bclk_rise = bclk_q[1] & ~bclk_q[2];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         sync_q <= '1;
      else if (bclk_rise) sync_q <= raw_n;

   assign act = ~(sync_mode ? sync_q : chain[SYNC_STAGES-1]);

   // R9: sampled strobes move only at a detected bus clock edge
   assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_rise |=> $stable(sync_q));
endmodule

// File: rtl/mpu_bus_fsm.sv
module mpu_bus_fsm
   import mpu_bus_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              rd_s,
   input  logic              wr_s,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              rdy,
   output logic              oe,
   output logic              we,
   output logic              wr_done,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);
   bus_state_e st, st_nx;
   logic start_rd, start_wr;

   assign start_rd = (st == ST_IDLE) && cs_s && rd_s && !wr_s;
   assign start_wr = (st == ST_IDLE) && cs_s && wr_s && !rd_s;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (cs_s && (rd_s || wr_s))
                      st_nx = (rd_s && wr_s) ? ST_SPENT : (rd_s ? ST_RD : ST_WR);
         ST_RD:    if (!rd_s || !cs_s) st_nx = ST_SPENT;
         ST_WR:    st_nx = ST_WHOLD;
         ST_WHOLD: if (!wr_s || !cs_s) st_nx = ST_SPENT;
         ST_SPENT: if (!cs_s) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         st <= st_nx;
         if (start_wr) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end else if (start_rd) begin
            addr_q <= addr_i;
         end
      end

   assign rdy     = (st == ST_RD) || (st == ST_WHOLD);
   assign oe      = (st == ST_RD);
   assign we      = (st == ST_WR);
   assign wr_done = (st == ST_WHOLD);

   assert_idle_no_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) && !cs_s |=> (st == ST_IDLE));
   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rdy && !rd_s && !wr_s |=> !rdy && !oe);
   assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SPENT) && cs_s |=> !rdy && !we);
   assert_both_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) && cs_s && rd_s && wr_s |=> !rdy && !we);
endmodule

// File: rtl/mpu_regfile.sv
module mpu_regfile #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end

   assign rdata = mem[addr];
endmodule

// File: rtl/mpu_reg_slave.sv
module mpu_reg_slave
   import mpu_bus_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              bus_clk,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] data,
   output logic              rdy_n
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W out of supported range 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [2:0]        act;
   logic              rdy, oe, we, wr_done;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata;

   mpu_strobe_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_mode (sync_mode),
      .bus_clk   (bus_clk),
      .raw_n     ({cs_n, rd_n, wr_n}),
      .act       (act)
   );

   mpu_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s    (act[B_CS]),
      .rd_s    (act[B_RD]),
      .wr_s    (act[B_WR]),
      .addr_i  (addr),
      .wdata_i (data),
      .rdy     (rdy),
      .oe      (oe),
      .we      (we),
      .wr_done (wr_done),
      .addr_q  (addr_q),
      .wdata_q (wdata_q)
   );

   mpu_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .addr  (addr_q),
      .wdata (wdata_q),
      .rdata (rdata)
   );

   assign rdy_n = ~rdy;
   assign data  = oe ? rdata : 'z;

   // R4: by the time ready is shown for a write, the location holds the data
   assert_write_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (rdata == wdata_q));
endmodule

// File: tb/mpu_reg_slave_tb.sv
module mpu_reg_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BCLK_HALF  = 15;

   logic       clk = 0, bus_clk = 0;
   logic       rst_n = 0, sync_mode = 0;
   logic       cs_n = 1, rd_n = 1, wr_n = 1;
   logic [7:0] addr = 0, tb_d = 0;
   logic       tb_oe = 0;
   logic       rdy_n;
   wire  [7:0] data;
   int         errors = 0, checks = 0;
   bit         done = 0;

   assign data = tb_oe ? tb_d : 'z;

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(BCLK_HALF) bus_clk = ~bus_clk;

   mpu_reg_slave u_dut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .bus_clk(bus_clk),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data(data),
      .rdy_n(rdy_n)
   );

   function automatic logic [7:0] pat_a(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rdy(input logic lvl, output bit ok);
      ok = 0;
      for (int i = 0; i < 60; i++) begin
         if (rdy_n == lvl) begin ok = 1; break; end
         tick(1);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
      bit ok;
      cs_n = 0; tick(1);
      addr = a; tb_d = d; tb_oe = 1; wr_n = 0;
      wait_rdy(1'b0, ok);
      if (!ok) chk(0, req, 1, 0);
      wr_n = 1;
      wait_rdy(1'b1, ok);
      if (!ok) chk(0, req, 0, 1);
      cs_n = 1; tb_oe = 0;
      tick(sync_mode ? 12 : 4);
   endtask

   task automatic do_read(input logic [7:0] a, output logic [7:0] d, input string req);
      bit ok;
      cs_n = 0; tick(1);
      addr = a; rd_n = 0;
      wait_rdy(1'b0, ok);
      if (!ok) chk(0, req, 1, 0);
      d = data;
      rd_n = 1;
      wait_rdy(1'b1, ok);
      if (!ok) chk(0, req, 0, 1);
      cs_n = 1;
      tick(sync_mode ? 12 : 4);
   endtask

   initial begin
      logic [7:0] rv;
      bit         stayed;
      int         n;

      // R1: ready inactive during reset
      tick(3);
      chk(rdy_n === 1'b1, "R1 reset rdy_n", rdy_n, 1);
      rst_n = 1;
      tick(3);
      chk(rdy_n === 1'b1, "R1 post-reset rdy_n", rdy_n, 1);
      for (int a = 0; a < 256; a++) begin
         do_read(8'(a), rv, "R1 read");
         chk(rv == 8'h00, "R1 cleared location", rv, 0);
      end

      // R2: strobes while deselected
      addr = 8'd9; tb_d = 8'h55; tb_oe = 1; wr_n = 0;
      stayed = 1;
      for (int i = 0; i < 10; i++) begin tick(1); if (!rdy_n) stayed = 0; end
      wr_n = 1; tb_oe = 0; tick(4);
      chk(stayed, "R2 no ready while deselected", !stayed, 0);
      do_read(8'd9, rv, "R2 read");
      chk(rv == 8'h00, "R2 location untouched", rv, 0);

      // R5/R6: exact write latency
      cs_n = 0; tick(3);
      addr = 8'd3; tb_d = 8'h5A; tb_oe = 1; wr_n = 0;
      n = 0;
      for (int i = 1; i <= 10; i++) begin tick(1); if (!rdy_n) begin n = i; break; end end
      chk(n == 4, "R5 write ready latency", n, 4);
      wr_n = 1;
      n = 0;
      for (int i = 1; i <= 10; i++) begin tick(1); if (rdy_n) begin n = i; break; end end
      chk(n == 3, "R6 write release latency", n, 3);
      cs_n = 1; tb_oe = 0; tick(4);

      // R5/R6/R3/R4: exact read latency and stored data
      cs_n = 0; tick(3);
      addr = 8'd3; rd_n = 0;
      n = 0;
      for (int i = 1; i <= 10; i++) begin tick(1); if (!rdy_n) begin n = i; break; end end
      chk(n == 3, "R5 read ready latency", n, 3);
      chk(data == 8'h5A, "R4 R3 read of written value", data, 8'h5A);
      rd_n = 1;
      n = 0;
      for (int i = 1; i <= 10; i++) begin tick(1); if (rdy_n) begin n = i; break; end end
      chk(n == 3, "R6 read release latency", n, 3);
      cs_n = 1; tick(4);

      // R10/R3/R4: full address sweep
      for (int a = 0; a < 256; a++) do_write(8'(a), pat_a(a), "R10 write");
      for (int a = 0; a < 256; a++) begin
         do_read(8'(a), rv, "R10 read");
         chk(rv == pat_a(a), "R10 R3 sweep readback", rv, pat_a(a));
      end

      // R7: second command in one select window
      cs_n = 0; tick(1);
      addr = 8'd5; tb_d = 8'hA5; tb_oe = 1; wr_n = 0;
      wait_rdy(1'b0, stayed);
      wr_n = 1;
      wait_rdy(1'b1, stayed);
      tick(4);
      tb_d = 8'h3C; wr_n = 0;
      stayed = 1;
      for (int i = 0; i < 12; i++) begin tick(1); if (!rdy_n) stayed = 0; end
      wr_n = 1; cs_n = 1; tb_oe = 0; tick(4);
      chk(stayed, "R7 no ready for second strobe", !stayed, 0);
      do_read(8'd5, rv, "R7 read");
      chk(rv == 8'hA5, "R7 second write blocked", rv, 8'hA5);
      do_write(8'd5, 8'h3C, "R7 rearmed write");
      do_read(8'd5, rv, "R7 read");
      chk(rv == 8'h3C, "R7 accepted after rearm", rv, 8'h3C);

      // R8: both strobes low together
      cs_n = 0; tick(3);
      addr = 8'd7; tb_d = 8'h99; tb_oe = 1; rd_n = 0; wr_n = 0;
      stayed = 1;
      for (int i = 0; i < 10; i++) begin tick(1); if (!rdy_n) stayed = 0; end
      rd_n = 1; wr_n = 1; cs_n = 1; tb_oe = 0; tick(4);
      chk(stayed, "R8 no ready on invalid cycle", !stayed, 0);
      do_read(8'd7, rv, "R8 read");
      chk(rv == pat_a(7), "R8 location unchanged", rv, pat_a(7));

      // R9: bus-clocked sampling
      sync_mode = 1; tick(10);
      for (int i = 0; i < 32; i++) do_write(8'(i * 8), 8'((i * 8) ^ 8'hC3), "R9 write");
      for (int i = 0; i < 32; i++) begin
         do_read(8'(i * 8), rv, "R9 read");
         chk(rv == 8'((i * 8) ^ 8'hC3), "R9 sync readback", rv, (i * 8) ^ 8'hC3);
      end
      do_read(8'd1, rv, "R9 read");
      chk(rv == pat_a(1), "R9 R10 neighbour untouched", rv, pat_a(1));

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule